// File: doc/BRIEF.md
# Processor Stack and Status Save Unit

This unit owns a processor's 8-bit stack pointer and runs the memory traffic for every stack operation. It handles single bytes, 16-bit words, saving and restoring the status register, and the call and return sequences for subroutines. The stack lives in one fixed 256-byte page. Each stack access goes to the page base concatenated with the pointer. The pointer is decremented after every write. Before every read it is incremented.

The unit has a simple command handshake. A one-cycle `start` with an operation code on `op` is accepted only while `busy` is low. The unit then runs one step per clock. Each step is one of four kinds: a memory write, a memory read, a discarded read at the program counter, or an internal cycle with no bus access. When the steps are finished, `done` pulses for one cycle and `dout` holds any pulled value. A free-running counter adds one for every cycle the unit is busy, so the cost of each operation can be read from the difference.

Top module: `stk_unit`

## Requirements
- R1: After reset the pointer equals the parameter SP_INIT (default 0xFD). The cycle counter, `busy` and `done` are all zero.
- R2: Every stack access puts the address {STACK_PAGE, sp} on `mem_addr`. The default page is 0x01.
- R3: Op code 0 (byte push) runs in 2 cycles. The first is a discarded read at `pc`. The second writes `din[7:0]` at the pointer. The pointer then drops by one and wraps from 0x00 to 0xFF.
- R4: Op code 1 (word push) runs in 2 cycles and has no dummy read. It writes `din[15:8]` at sp and then `din[7:0]` at sp-1. The pointer ends 2 lower.
- R5: Op code 2 (byte pull) runs in 3 cycles. They are a discarded read at `pc`, an internal cycle that increments the pointer, and a read at the new pointer. `dout` = {8'h00, byte}. The pointer wraps from 0xFF to 0x00.
- R6: Op code 3 (word pull) runs in 3 cycles. An internal increment comes first. Then it reads the low byte at sp+1 and the high byte at sp+2. `dout` = {high, low}.
- R7: Op code 4 (status save) behaves like a byte push, except that bit 4 of the stored byte is forced to 1. The other bits are copied from `din[7:0]`.
- R8: Op code 5 (status restore) behaves like a byte pull, except that bit 5 of `dout` is forced to 1 and bit 4 is forced to 0.
- R9: Op code 6 (call) runs in 3 cycles. One internal cycle comes first. Then the unit pushes `din`-1 (mod 2^16), high byte first.
- R10: Op code 7 (return) runs in 4 cycles. They are a dummy read at `pc`, an internal increment, a low read and a high read. `dout` = {high, low}+1 (mod 2^16).
- R11: The cycle counter rises by exactly one on each busy cycle and holds its value while the unit is idle.
- R12: A `start` seen while busy is ignored. `done` is a single-cycle pulse, issued with `busy` low in the cycle after the last step.
- R13: At most one of `mem_we` and `mem_re` is high in any cycle. Internal cycles and idle cycles make no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code, see R3 to R10 |
| din | input | 16 | Byte, word or status value to store |
| pc | input | 16 | Program counter used for the dummy read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 16 | Pulled value |
| sp | output | 8 | Current stack pointer |
| cyc_count | output | CYC_W | Busy-cycle counter |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |

## Verification
The embedded properties check a set of rules on every cycle:
- the write address sits on the stack page at the current pointer;
- there is no more than one access per cycle, and none on internal steps;
- the forced bit in a saved status byte;
- the forced bits in a restored status value;
- pointer wrap in both directions;
- the counter's step-or-hold rule;
- `done` behaving as a single pulse while a command held during `busy` is left unlatched.

Some behaviours only the scoreboard scenarios can show:
- the exact order of dummy reads, internal cycles, writes and reads for each operation;
- the byte order of word transfers;
- the -1 and +1 adjustments on call and return;
- the per-operation cycle totals.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam int BRK_BIT = 4;
  localparam int UNU_BIT = 5;

  typedef enum logic [2:0] {
    OP_PUSH_B  = 3'd0,
    OP_PUSH_W  = 3'd1,
    OP_PULL_B  = 3'd2,
    OP_PULL_W  = 3'd3,
    OP_SAVE_ST = 3'd4,
    OP_LOAD_ST = 3'd5,
    OP_CALL    = 3'd6,
    OP_RET     = 3'd7
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DUMMY, ST_INTL, ST_INC, ST_WR_HI, ST_WR_LO, ST_RD_LO, ST_RD_HI
  } stk_step_e;

  function automatic logic [7:0] status_save(input logic [7:0] v);
    logic [7:0] r;
    r = v;
    r[BRK_BIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] status_restore(input logic [7:0] v);
    logic [7:0] r;
    r = v;
    r[UNU_BIT] = 1'b1;
    r[BRK_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] stack_addr(input logic [7:0] page, input logic [7:0] ptr);
    return {page, ptr};
  endfunction

  function automatic logic [15:0] call_adjust(input logic [15:0] w);
    return w - 16'd1;
  endfunction

  function automatic logic [15:0] ret_adjust(input logic [15:0] w, input logic add);
    return w + {15'd0, add};
  endfunction

  function automatic logic needs_dummy(input stk_op_e o);
    return (o == OP_PUSH_B) || (o == OP_PULL_B) || (o == OP_SAVE_ST) ||
           (o == OP_LOAD_ST) || (o == OP_RET);
  endfunction

  function automatic logic is_pull(input stk_op_e o);
    return (o == OP_PULL_B) || (o == OP_PULL_W) || (o == OP_LOAD_ST) || (o == OP_RET);
  endfunction

  function automatic logic is_word_pull(input stk_op_e o);
    return (o == OP_PULL_W) || (o == OP_RET);
  endfunction

  function automatic stk_step_e first_step(input stk_op_e o);
    if (needs_dummy(o))     return ST_DUMMY;
    else if (o == OP_CALL)  return ST_INTL;
    else if (o == OP_PUSH_W) return ST_WR_HI;
    else                    return ST_INC;
  endfunction

  function automatic stk_step_e next_step(input stk_op_e o, input stk_step_e s);
    case (s)
      ST_DUMMY: return is_pull(o) ? ST_INC : ST_WR_LO;
      ST_INTL:  return ST_WR_HI;
      ST_WR_HI: return ST_WR_LO;
      ST_INC:   return ST_RD_LO;
      ST_RD_LO: return is_word_pull(o) ? ST_RD_HI : ST_IDLE;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  stk_op_e   op_in,
  output stk_op_e   op_q,
  output stk_step_e step,
  output logic      busy,
  output logic      done,
  output logic      accept,
  output logic      last
);

  assign busy   = (step != ST_IDLE);
  assign accept = start && !busy;
  assign last   = busy && (next_step(op_q, step) == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= ST_IDLE;
      op_q <= OP_PUSH_B;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        step <= first_step(op_in);
        op_q <= op_in;
      end else if (busy) begin
        step <= next_step(op_q, step);
      end
    end
  end

  // R12: command held during busy does not replace the latched one
  p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> op_q == $past(op_q));
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter logic [7:0] SP_INIT = 8'hFD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       dec,
  output logic [7:0] sp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)   sp_q <= SP_INIT;
    else if (inc) sp_q <= sp_q + 8'd1;
    else if (dec) sp_q <= sp_q - 8'd1;
  end

  p_no_conflict_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));
  p_wrap_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec && (sp_q == 8'h00) |=> sp_q == 8'hFF);
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc && (sp_q == 8'hFF) |=> sp_q == 8'h00);

endmodule

// File: rtl/stk_cyc_ctr.sv
module stk_cyc_ctr #(
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CYC_W-1:0] count
);

  localparam logic [CYC_W-1:0] ONE = {{(CYC_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + ONE;
  end

  p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + ONE);
  p_count_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter logic [7:0] STACK_PAGE = 8'h01,
  parameter logic [7:0] SP_INIT    = 8'hFD,
  parameter int         CYC_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [15:0]      din,
  input  logic [15:0]      pc,
  output logic             busy,
  output logic             done,
  output logic [15:0]      dout,
  output logic [7:0]       sp,
  output logic [CYC_W-1:0] cyc_count,
  output logic [15:0]      mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata
);

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  stk_op_e     op_q;
  stk_step_e   step;
  logic        accept, last;
  logic        sp_inc, sp_dec;
  logic [WORD_W-1:0] data_q, pc_q, dout_q;

  stk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(stk_op_e'(op)),
    .op_q(op_q), .step(step), .busy(busy), .done(done),
    .accept(accept), .last(last)
  );

  assign sp_dec = (step == ST_WR_HI) || (step == ST_WR_LO);
  assign sp_inc = (step == ST_INC) || ((step == ST_RD_LO) && is_word_pull(op_q));

  stk_ptr #(.SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec), .sp_q(sp)
  );

  stk_cyc_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(busy), .count(cyc_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      pc_q   <= '0;
    end else if (accept) begin
      data_q <= (stk_op_e'(op) == OP_CALL) ? call_adjust(din) : din;
      pc_q   <= pc;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    case (step)
      ST_DUMMY: begin
        mem_addr = pc_q;
        mem_re   = 1'b1;
      end
      ST_WR_HI: begin
        mem_addr  = stack_addr(STACK_PAGE, sp);
        mem_we    = 1'b1;
        mem_wdata = data_q[WORD_W-1:BYTE_W];
      end
      ST_WR_LO: begin
        mem_addr  = stack_addr(STACK_PAGE, sp);
        mem_we    = 1'b1;
        mem_wdata = (op_q == OP_SAVE_ST) ? status_save(data_q[BYTE_W-1:0])
                                         : data_q[BYTE_W-1:0];
      end
      ST_RD_LO, ST_RD_HI: begin
        mem_addr = stack_addr(STACK_PAGE, sp);
        mem_re   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (step == ST_RD_LO) begin
      if (op_q == OP_LOAD_ST) dout_q <= {8'h00, status_restore(mem_rdata)};
      else                    dout_q <= {8'h00, mem_rdata};
    end else if (step == ST_RD_HI) begin
      dout_q <= ret_adjust({mem_rdata, dout_q[BYTE_W-1:0]}, op_q == OP_RET);
    end
  end

  assign dout = dout_q;

  p_single_access_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_internal_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_INTL || step == ST_INC || !busy) |-> !mem_we && !mem_re);
  p_write_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE && mem_addr[7:0] == sp);
  p_save_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && op_q == OP_SAVE_ST |-> mem_wdata[BRK_BIT]);
  p_restore_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == OP_LOAD_ST |-> dout[UNU_BIT] && !dout[BRK_BIT]);

endmodule

// File: tb/stk_unit_test.sv
module stk_unit_test;

  localparam logic [7:0] PAGE  = 8'h01;
  localparam logic [7:0] SPI   = 8'hFD;
  localparam logic [2:0] C_PUSH_B = 3'd0, C_PUSH_W = 3'd1, C_PULL_B = 3'd2,
                         C_PULL_W = 3'd3, C_SAVE = 3'd4, C_LOAD = 3'd5,
                         C_CALL = 3'd6, C_RET = 3'd7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [15:0] din = '0, pc = '0;
  logic busy, done, mem_re, mem_we;
  logic [15:0] dout, mem_addr;
  logic [7:0] sp, mem_wdata, mem_rdata;
  logic [31:0] cyc_count;

  always #4 clk = ~clk;

  stk_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .din(din), .pc(pc),
    .busy(busy), .done(done), .dout(dout), .sp(sp), .cyc_count(cyc_count),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] smem [256];
  assign mem_rdata = (mem_addr[15:8] == PAGE) ? smem[mem_addr[7:0]] : 8'hEA;
  always @(posedge clk) if (mem_we) smem[mem_addr[7:0]] <= mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct { int kind; logic [15:0] addr; logic [7:0] data; string req; } acc_t;
  typedef struct { bit chk_dout; logic [15:0] dout; logic [7:0] sp; int cyc; string req; } res_t;
  acc_t acc_q[$];
  res_t res_q[$];

  function automatic void exp_acc(input int k, input logic [15:0] a,
                                  input logic [7:0] d, input string rq);
    acc_t e;
    e.kind = k; e.addr = a; e.data = d; e.req = rq;
    acc_q.push_back(e);
  endfunction

  // monitor: one expected bus step per busy cycle, result on done
  always @(negedge clk) begin
    acc_t e;
    res_t r;
    int k;
    if (rst_n) begin
      k = mem_we ? 2 : (mem_re ? 1 : 0);
      chk(!(mem_we && mem_re), "R13", "dual access", {mem_we, mem_re}, 0);
      if (busy) begin
        if (acc_q.size() == 0) chk(0, "R12", "unexpected busy cycle", 1, 0);
        else begin
          e = acc_q.pop_front();
          chk(k == e.kind, e.req, "access kind", k, e.kind);
          if (e.kind != 0) chk(mem_addr == e.addr, e.req, "address", mem_addr, e.addr);
          if (e.kind == 2) chk(mem_wdata == e.data, e.req, "write data", mem_wdata, e.data);
        end
      end else begin
        chk(k == 0, "R13", "access while idle", k, 0);
      end
      if (done) begin
        chk(!busy, "R12", "busy with done", busy, 0);
        if (res_q.size() == 0) chk(0, "R12", "unexpected done", 1, 0);
        else begin
          r = res_q.pop_front();
          chk(sp == r.sp, r.req, "sp", sp, r.sp);
          chk(cyc_count == r.cyc, "R11", "cycle count", cyc_count, r.cyc);
          if (r.chk_dout) chk(dout == r.dout, r.req, "dout", dout, r.dout);
        end
      end
    end
  end

  logic [7:0] m_sp = SPI;
  int m_cyc = 0;

  task automatic run(input logic [2:0] o, input logic [15:0] d,
                     input logic [15:0] p, input bit hold, input string rq);
    res_t r;
    logic [15:0] w;
    logic [7:0] lo, hi;
    int n;
    r.chk_dout = 0; r.dout = '0; r.req = rq;
    n = 0;
    case (o)
      C_PUSH_B, C_SAVE: begin
        exp_acc(1, p, 0, rq);
        exp_acc(2, {PAGE, m_sp}, (o == C_SAVE) ? (d[7:0] | 8'h10) : d[7:0], rq);
        m_sp = m_sp - 8'd1; n = 2;
      end
      C_PUSH_W, C_CALL: begin
        w = d;
        n = 2;
        if (o == C_CALL) begin exp_acc(0, 0, 0, rq); w = d - 16'd1; n = 3; end
        exp_acc(2, {PAGE, m_sp}, w[15:8], rq); m_sp = m_sp - 8'd1;
        exp_acc(2, {PAGE, m_sp}, w[7:0], rq);  m_sp = m_sp - 8'd1;
      end
      C_PULL_B, C_LOAD: begin
        exp_acc(1, p, 0, rq);
        exp_acc(0, 0, 0, rq);
        m_sp = m_sp + 8'd1;
        exp_acc(1, {PAGE, m_sp}, 0, rq);
        lo = smem[m_sp];
        r.chk_dout = 1;
        r.dout = (o == C_LOAD) ? {8'h00, (lo | 8'h20) & 8'hEF} : {8'h00, lo};
        n = 3;
      end
      default: begin // word pull or return
        n = 3;
        if (o == C_RET) begin exp_acc(1, p, 0, rq); n = 4; end
        exp_acc(0, 0, 0, rq);
        m_sp = m_sp + 8'd1; exp_acc(1, {PAGE, m_sp}, 0, rq); lo = smem[m_sp];
        m_sp = m_sp + 8'd1; exp_acc(1, {PAGE, m_sp}, 0, rq); hi = smem[m_sp];
        r.chk_dout = 1;
        r.dout = {hi, lo} + ((o == C_RET) ? 16'd1 : 16'd0);
      end
    endcase
    m_cyc = m_cyc + n;
    r.sp = m_sp; r.cyc = m_cyc;
    res_q.push_back(r);
    @(posedge clk); #1;
    start = 1'b1; op = o; din = d; pc = p;
    @(posedge clk); #1;
    if (hold) begin
      op = C_PULL_B; din = 16'hDEAD;
      @(posedge clk); #1;
    end
    start = 1'b0;
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    chk(0, "R12", "watchdog expired", 1, 0);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(sp == SPI, "R1", "reset sp", sp, SPI);
    chk(cyc_count == 0, "R1", "reset count", cyc_count, 0);
    chk(!busy, "R1", "reset busy", busy, 0);
    chk(!done, "R1", "reset done", done, 0);
    repeat (2) @(negedge clk);
    chk(cyc_count == 0, "R11", "idle hold", cyc_count, 0);

    run(C_PUSH_B, 16'h00A5, 16'hC000, 0, "R3");
    run(C_SAVE,   16'h0042, 16'hC001, 0, "R7");
    run(C_LOAD,   16'h0000, 16'hC002, 0, "R8");
    run(C_PULL_B, 16'h0000, 16'hC003, 0, "R5");
    run(C_PUSH_W, 16'h1234, 16'hC004, 0, "R4");
    run(C_PULL_W, 16'h0000, 16'hC005, 0, "R6");
    run(C_CALL,   16'h8000, 16'hC006, 1, "R9");   // R12: start held while busy
    run(C_RET,    16'h0000, 16'hC007, 0, "R10");
    run(C_PUSH_W, 16'hFFFF, 16'hC008, 0, "R4");
    run(C_RET,    16'h0000, 16'hC009, 1, "R10");  // wraps to 0x0000
    run(C_PULL_B, 16'h0000, 16'hC00A, 0, "R5");
    run(C_PULL_B, 16'h0000, 16'hC00B, 0, "R5");
    run(C_PULL_B, 16'h0000, 16'hC00C, 0, "R5");   // sp FF -> 00
    run(C_PUSH_B, 16'h00FF, 16'hC00D, 0, "R3");   // sp 00 -> FF
    run(C_LOAD,   16'h0000, 16'hC00E, 0, "R8");
    run(C_SAVE,   16'h0000, 16'hC00F, 0, "R7");
    run(C_LOAD,   16'h0000, 16'hC010, 0, "R8");
    run(C_PUSH_W, 16'hBEEF, 16'hC011, 0, "R2");

    repeat (3) @(negedge clk);
    chk(cyc_count == m_cyc, "R11", "idle hold at end", cyc_count, m_cyc);
    chk(acc_q.size() == 0, "R12", "leftover steps", acc_q.size(), 0);
    chk(res_q.size() == 0, "R12", "leftover results", res_q.size(), 0);
    finish_up();
  end

endmodule